// File: doc/BRIEF.md
# Output Driver Impedance Calibration Sequencer

This block tunes the pull-up strength of the output drivers. The on-die resistor leg never comes out at its nominal value, and it drifts with temperature. The external precision resistor stays fixed, so it serves as the reference. A long calibration request may only be issued while the interface is being initialized. When one arrives, the sequencer sweeps a pull-up tuning code upward from zero and drives it onto the analog calibration leg. After every step it waits a fixed settle time. It then reads a comparator that reports whether the divider node formed by the leg and the reference resistor lies above or below half of the I/O supply.

The code at zero gives the starting polarity of the comparator. The first higher code at which the comparator reports the opposite polarity is taken as the calibrated value. That one value is then written into the tuning field of every data lane at the same moment. If the sweep reaches the all-ones code and the polarity has not changed, the block keeps the maximum code and raises an error flag. A busy flag covers the whole sweep, and a one-cycle done pulse marks its end.

Top module: `zq_cal_ctrl`

## Requirements
- R1: After reset, busy_o, done_o and err_o are low, and code_o and every lane field are zero.
- R2: A start_i pulse starts calibration only if init_i is high on the same clock edge. With init_i low, the pulse has no effect on any output.
- R3: On an accepted start, code_o becomes 0 at that edge and then rises by exactly one every SETTLE clocks. With the default SETTLE of 8, the code value j appears 8·j edges after the accepting edge.
- R4: cmp_i is sampled on the last clock of each settle interval. The sample taken at code 0 sets the reference polarity. The result is the first code k ≥ 1 whose sample differs from the reference, and either polarity of the reference is handled.
- R5: At completion, lane field i (bits [i·5 +: 5] for the 5-bit code) of lane_code_o receives the result in every lane at the same time. The lane fields change at no other time.
- R6: busy_o is high from the accepting edge until the edge (k+1)·SETTLE later. On that edge, busy_o falls and done_o is high for exactly one cycle.
- R7: If no polarity change has occurred by the sample at code 31, completion still happens at that sample, with err_o high and with code_o and all lanes at 31. A flip seen exactly at code 31 completes with err_o low. The next accepted start clears err_o.
- R8: A start_i pulse while busy_o is high is ignored. The sweep keeps its code sequence and its completion time.
- R9: After completion, code_o holds the result until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Long calibration request pulse |
| init_i | input | 1 | High while the interface is initializing |
| cmp_i | input | 1 | Comparator: divider node above half supply |
| code_o | output | CODE_W | Pull-up tuning code to the analog calibration leg |
| lane_code_o | output | LANES*CODE_W | Per-lane pull-up tuning fields |
| busy_o | output | 1 | Sweep in progress |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | Sweep saturated without a polarity change |

## Verification
The analog environment is modelled as a trip code: the comparator changes state once code_o reaches the trip code, and the polarity can be inverted. The tests run trip codes 1, 5 and 31, which check the smallest result, a middle result and a flip on the last possible code. An inverted trip at 12 shows that the block reacts to a change of polarity rather than to a fixed level. A trip code that is never reached forces saturation and the error path, and a normal run afterwards shows that the error clears. A start pulse with init_i low, and a second start pulse in the middle of a sweep, show that both are ignored.

// File: rtl/zq_cal_ctrl.sv
module zq_cal_ctrl #(
  parameter int LANES  = 4,
  parameter int CODE_W = 5,
  parameter int SETTLE = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start_i,
  input  logic                    init_i,
  input  logic                    cmp_i,
  output logic [CODE_W-1:0]       code_o,
  output logic [LANES*CODE_W-1:0] lane_code_o,
  output logic                    busy_o,
  output logic                    done_o,
  output logic                    err_o
);
  localparam int CNT_W = (SETTLE > 1) ? $clog2(SETTLE) : 1;
  localparam logic [CODE_W-1:0] CODE_MAX = '1;
  localparam logic [CNT_W-1:0]  CNT_LAST = CNT_W'(SETTLE - 1);

  logic [CNT_W-1:0] cnt;
  logic             ref_pol;

  wire go     = start_i && init_i && !busy_o;
  wire tick   = busy_o && (cnt == CNT_LAST);
  wire flip   = tick && (code_o != '0) && (cmp_i != ref_pol);
  wire sat    = tick && !flip && (code_o == CODE_MAX);
  wire finish = flip || sat;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt         <= '0;
      ref_pol     <= 1'b0;
      code_o      <= '0;
      lane_code_o <= '0;
      busy_o      <= 1'b0;
      done_o      <= 1'b0;
      err_o       <= 1'b0;
    end else begin
      done_o <= finish;
      if (go) begin
        busy_o <= 1'b1;
        code_o <= '0;
        cnt    <= '0;
        err_o  <= 1'b0;
      end else if (busy_o) begin
        cnt <= tick ? '0 : cnt + 1'b1;
        if (tick) begin
          if (code_o == '0) ref_pol <= cmp_i;
          if (finish) begin
            busy_o      <= 1'b0;
            err_o       <= sat;
            lane_code_o <= {LANES{code_o}};
          end else begin
            code_o <= code_o + 1'b1;
          end
        end
      end
    end
  end

  // R6
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R6
  done_ends_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (!busy_o && $past(busy_o)));

  // R3
  code_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && $past(busy_o)) |-> (code_o == $past(code_o) || code_o == $past(code_o) + 1'b1));

  // R3
  code_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> (code_o == '0));

  // R7
  err_max_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && err_o) |-> (code_o == CODE_MAX));

  // R9
  code_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && $past(!busy_o)) |-> $stable(code_o));

  genvar gi;
  generate
    for (gi = 0; gi < LANES; gi++) begin : g_lane_chk
      // R5
      lane_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (lane_code_o[gi*CODE_W +: CODE_W] == code_o));
    end
  endgenerate
endmodule

// File: tb/zq_cal_ctrl_test.sv
module zq_cal_ctrl_test;
  localparam int LANES  = 4;
  localparam int CODE_W = 5;
  localparam int SETTLE = 8;
  localparam int MAXC   = (1 << CODE_W) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 1'b0;
  logic init_i = 1'b0;
  logic cmp_i;
  logic [CODE_W-1:0]       code_o;
  logic [LANES*CODE_W-1:0] lane_code_o;
  logic busy_o, done_o, err_o;

  int trip = 100;
  bit inv  = 1'b0;
  int vectors = 0;
  int fails   = 0;
  int cycles  = 0;
  bit ended   = 1'b0;

  always #2.5 clk = ~clk;

  assign cmp_i = inv ^ (int'(code_o) >= trip);

  zq_cal_ctrl #(.LANES(LANES), .CODE_W(CODE_W), .SETTLE(SETTLE)) uut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .init_i(init_i), .cmp_i(cmp_i),
    .code_o(code_o), .lane_code_o(lane_code_o), .busy_o(busy_o),
    .done_o(done_o), .err_o(err_o));

  // behavioural reference
  bit m_busy, m_done, m_err;
  int m_code, m_t, m_k, m_lane;
  bit m_sat;

  function automatic bit env_cmp(int c);
    return inv ^ (c >= trip);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_busy = 0; m_done = 0; m_err = 0; m_code = 0; m_t = 0; m_lane = 0;
    end else begin
      m_done = 0;
      if (start_i && init_i && !m_busy) begin
        m_busy = 1; m_t = 0; m_code = 0; m_err = 0;
        m_k = MAXC; m_sat = 1;
        for (int c = MAXC; c >= 1; c--)
          if (env_cmp(c) != env_cmp(0)) begin m_k = c; m_sat = 0; end
      end else if (m_busy) begin
        m_t++;
        m_code = m_t / SETTLE;
        if (m_t == (m_k + 1) * SETTLE) begin
          m_code = m_k; m_busy = 0; m_done = 1; m_err = m_sat; m_lane = m_k;
        end
      end
    end
  end

  task automatic check(string req, string what, int act, int exp);
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!ended) begin
      check("R6", "busy", busy_o, m_busy);
      check("R6", "done", done_o, m_done);
      check("R3", "code", code_o, m_code);
      check("R7", "err", err_o, m_err);
      for (int i = 0; i < LANES; i++)
        check("R5", "lane", lane_code_o[i*CODE_W +: CODE_W], m_lane);
    end
  end

  task automatic pulse_start(bit init);
    @(negedge clk);
    init_i = init; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0; init_i = 1'b0;
  endtask

  task automatic run(int t, bit iv, int exp_k, bit exp_err, string req);
    trip = t; inv = iv;
    pulse_start(1'b1);
    while (busy_o) @(negedge clk);
    check(req, "result code", code_o, exp_k);
    check(req, "result err", err_o, exp_err);
    check("R5", "lane 0 result", lane_code_o[0 +: CODE_W], exp_k);
    check("R5", "top lane result", lane_code_o[(LANES-1)*CODE_W +: CODE_W], exp_k);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1", "reset busy", busy_o, 0);
    check("R1", "reset code", code_o, 0);
    check("R1", "reset lanes", int'(lane_code_o), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R2: start without init ignored
    trip = 5; inv = 0;
    pulse_start(1'b0);
    repeat (20) @(negedge clk);
    check("R2", "busy after start without init", busy_o, 0);
    check("R2", "code after start without init", code_o, 0);

    run(5, 0, 5, 0, "R4");
    // R9: result held
    repeat (30) @(negedge clk);
    check("R9", "held code", code_o, 5);

    // R8: second start mid-sweep ignored
    trip = 9; inv = 0;
    pulse_start(1'b1);
    repeat (20) @(negedge clk);
    pulse_start(1'b1);
    while (busy_o) @(negedge clk);
    check("R8", "result after restart attempt", code_o, 9);

    run(1, 0, 1, 0, "R4");
    run(12, 1, 12, 0, "R4");
    run(31, 0, 31, 0, "R7");
    run(40, 0, 31, 1, "R7");
    repeat (5) @(negedge clk);
    check("R7", "err held after saturation", err_o, 1);
    run(3, 0, 3, 0, "R7");
    repeat (5) @(negedge clk);

    ended = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !ended) begin
      ended = 1'b1;
      fails++;
      $display("FAIL watchdog: actual %0d cycles expected under 100000", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end
endmodule